// File: doc/BRIEF.md
# Byte-Granular Instruction Prefetch Queue

This block is a small look-ahead buffer between an instruction memory that delivers 16-bit words and an execution unit that consumes bytes. It holds up to five bytes, which covers the longest four-byte instruction with one byte to spare. It fills itself one word at a time from a fetch pointer it keeps. Whenever at least two byte slots are free it raises a refill request carrying the word-aligned address. The first three bytes at the head are always shown on a peek output, together with how many of them are valid. The execution unit can therefore inspect an opcode and its operand bytes before it commits to removing any of them.

Removal is variable-width. In one clock the consumer takes one byte, which is the usual case for an opcode. It can instead take a whole one-, two- or three-byte operand in that same single clock. A removal that asks for more bytes than the queue holds is refused and changes nothing. A removal and a refill may both happen in the same clock, and the byte order is kept.

The flush input serves two cases: a taken branch, and an explicit resynchronisation after code has been modified. It discards everything held and moves the fetch pointer to the supplied target address. If that target is odd, the first word fetched afterwards contributes only its upper byte.

Top module: `instr_prefetch_queue`

## Requirements
- R1: After reset the queue is empty (peekCount = 0), fetchAddr equals the reset address (0 by default) and fetchReq is high.
- R2: fetchReq is high exactly when at least two byte slots are free and flushValid is low. fetchAddr is the fetch pointer with bit 0 cleared. When fetchReq is low, fetchGrant is ignored.
- R3: An accepted fetch (fetchReq and fetchGrant) at an even pointer appends two bytes: first fetchData[7:0] (lower address), then fetchData[15:8]. The pointer advances by 2.
- R4: An accepted fetch at an odd pointer appends only fetchData[15:8]. The pointer advances by 1 to the next even address.
- R5: peekData[7:0] is the head byte, [15:8] the next byte and [23:16] the third. peekCount is the number of bytes held, capped at 3.
- R6: A removal (popValid with popReady) of popSize bytes, where popSize is 1, 2 or 3, removes that many bytes in one clock. The remaining bytes move to the head in their original order.
- R7: When popSize exceeds the number of bytes held, popReady is low and the queue contents stay unchanged.
- R8: While flushValid is high, popReady and fetchReq are low. On the next clock the queue is empty and fetchAddr reflects flushAddr.
- R9: A removal and an accepted fetch in the same clock both take effect. The appended bytes follow the bytes that remain.
- R10: The queue never holds more than five bytes. With four bytes held, no refill is requested. From three bytes held, one aligned fetch fills it to five.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flushValid | input | 1 | Discard queue and restart fetching at flushAddr |
| flushAddr | input | ADDR_W | Byte address to restart from |
| popValid | input | 1 | Consumer wants to remove bytes |
| popSize | input | 2 | Number of bytes to remove (1 to 3) |
| popReady | output | 1 | Removal of popSize bytes is possible this clock |
| peekData | output | 24 | Head three bytes, head in bits 7:0 |
| peekCount | output | 2 | Valid bytes in peekData (0 to 3) |
| fetchReq | output | 1 | Refill request |
| fetchAddr | output | ADDR_W | Word-aligned refill address |
| fetchGrant | input | 1 | Memory accepts the request, data valid this clock |
| fetchData | input | 16 | Instruction word, lower address in bits 7:0 |

## Verification
Aligned refills are issued back to back until the queue refuses more. This shows the two-free-slot request rule apart from a plain "not full" rule, because the queue stops at four bytes instead of filling to five. Odd flush targets show whether the first fetched word is split correctly. Reaching five held bytes through a single-byte fetch followed by two aligned fetches proves the full capacity is usable. Removals of one, two and three bytes are tried alone, together with a refill in the same clock, beyond the held count, and during a flush. These cases separate ordering faults, faults in the shift amount and faults in flush priority.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  // Width of byte counters inside the queue; supports depths up to 15.
  localparam int QCNT_W = 4;

  typedef struct packed {
    logic              clear;      // drop all held bytes
    logic [QCNT_W-1:0] shiftBy;    // bytes removed from the head this clock
    logic [QCNT_W-1:0] wrBase;     // slot where appended bytes begin
    logic [1:0]        wrBytes;    // bytes appended this clock (0..2)
    logic              wrHighOnly; // odd pointer: append the upper lane only
  } pfq_ctl_t;
endpackage

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
  import pfq_pkg::*;
#(
  parameter int DEPTH      = 5,
  parameter int ADDR_W     = 16,
  parameter int RESET_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushValid,
  input  logic [ADDR_W-1:0] flushAddr,
  input  logic              popValid,
  input  logic [1:0]        popSize,
  output logic              popReady,
  output logic [1:0]        peekCount,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchGrant,
  output pfq_ctl_t          ctl
);
  localparam logic [QCNT_W-1:0] DEPTH_C = QCNT_W'(DEPTH);

  logic [QCNT_W-1:0] count;
  logic [QCNT_W-1:0] freeSlots;
  logic [QCNT_W-1:0] popBytes;
  logic [QCNT_W-1:0] wrCount;
  logic [ADDR_W-1:0] fetchPtr;
  logic              doFetch;
  logic              doPop;

  assign freeSlots = DEPTH_C - count;
  assign fetchReq  = !flushValid && (freeSlots >= QCNT_W'(2));
  assign fetchAddr = {fetchPtr[ADDR_W-1:1], 1'b0};
  assign doFetch   = fetchReq && fetchGrant;

  assign popReady  = !flushValid && ({{(QCNT_W-2){1'b0}}, popSize} <= count);
  assign doPop     = popValid && popReady;
  assign popBytes  = doPop ? {{(QCNT_W-2){1'b0}}, popSize} : '0;

  assign wrCount   = doFetch ? (fetchPtr[0] ? QCNT_W'(1) : QCNT_W'(2)) : '0;
  assign peekCount = (count >= QCNT_W'(3)) ? 2'd3 : count[1:0];

  always_comb begin
    ctl.clear      = flushValid;
    ctl.shiftBy    = popBytes;
    ctl.wrBase     = count - popBytes;
    ctl.wrBytes    = wrCount[1:0];
    ctl.wrHighOnly = fetchPtr[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      fetchPtr <= ADDR_W'(RESET_ADDR);
    end else if (flushValid) begin
      count    <= '0;
      fetchPtr <= flushAddr;
    end else begin
      count    <= count - popBytes + wrCount;
      if (doFetch) fetchPtr <= fetchPtr + ADDR_W'(wrCount);
    end
  end

  // R10
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= DEPTH_C);

  // R8
  flush_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |=> (count == '0) && (fetchPtr == $past(flushAddr)));

  // R7
  refused_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flushValid && popValid && !popReady && !doFetch) |=> $stable(count));

  // R4
  odd_realign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!flushValid && doFetch && fetchPtr[0]) |=> !fetchPtr[0]);
endmodule

// File: rtl/pfq_data.sv
module pfq_data
  import pfq_pkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  pfq_ctl_t    ctl,
  input  logic [15:0] wrData,
  output logic [23:0] peekData
);
  logic [7:0] q   [DEPTH];
  logic [7:0] nxt [DEPTH];
  logic [7:0] headAfterPop;

  function automatic logic [7:0] pickByte(input logic [7:0] arr [DEPTH],
                                          input logic [QCNT_W-1:0] idx);
    logic [7:0] r;
    r = '0;
    for (int j = 0; j < DEPTH; j++)
      if (idx == QCNT_W'(j)) r = arr[j];
    return r;
  endfunction

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic [QCNT_W-1:0] lane;
      lane   = QCNT_W'(i);
      nxt[i] = q[i];
      if (!ctl.clear) begin
        if (lane < ctl.wrBase)
          nxt[i] = pickByte(q, lane + ctl.shiftBy);
        else if (ctl.wrBytes != 2'd0 && lane == ctl.wrBase)
          nxt[i] = ctl.wrHighOnly ? wrData[15:8] : wrData[7:0];
        else if (ctl.wrBytes == 2'd2 && lane == QCNT_W'(ctl.wrBase + 1'b1))
          nxt[i] = wrData[15:8];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rstN) q[i] <= '0;
      else       q[i] <= nxt[i];
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_peek
    assign peekData[8*g +: 8] = q[g];
  end

  assign headAfterPop = pickByte(q, ctl.shiftBy);

  // R6
  head_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.clear && ctl.wrBase != '0) |=> q[0] == $past(headAfterPop));

  // R3
  low_lane_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.clear && ctl.wrBase == '0 && ctl.wrBytes == 2'd2)
      |=> q[0] == $past(wrData[7:0]) && q[1] == $past(wrData[15:8]));
endmodule

// File: rtl/instr_prefetch_queue.sv
module instr_prefetch_queue
  import pfq_pkg::*;
#(
  parameter int DEPTH      = 5,
  parameter int ADDR_W     = 16,
  parameter int RESET_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushValid,
  input  logic [ADDR_W-1:0] flushAddr,
  input  logic              popValid,
  input  logic [1:0]        popSize,
  output logic              popReady,
  output logic [23:0]       peekData,
  output logic [1:0]        peekCount,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchGrant,
  input  logic [15:0]       fetchData
);
  pfq_ctl_t ctl;

  pfq_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .flushValid(flushValid), .flushAddr(flushAddr),
    .popValid(popValid), .popSize(popSize), .popReady(popReady),
    .peekCount(peekCount),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchGrant(fetchGrant),
    .ctl(ctl)
  );

  pfq_data #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .wrData(fetchData), .peekData(peekData)
  );
endmodule

// File: tb/instr_prefetch_queue_test.sv
module instr_prefetch_queue_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        flushValid;
  logic [15:0] flushAddr;
  logic        popValid;
  logic [1:0]  popSize;
  logic        popReady;
  logic [23:0] peekData;
  logic [1:0]  peekCount;
  logic        fetchReq;
  logic [15:0] fetchAddr;
  logic        fetchGrant;
  logic [15:0] fetchData;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_prefetch_queue uut (
    .clk(clk), .rstN(rstN),
    .flushValid(flushValid), .flushAddr(flushAddr),
    .popValid(popValid), .popSize(popSize), .popReady(popReady),
    .peekData(peekData), .peekCount(peekCount),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .fetchGrant(fetchGrant), .fetchData(fetchData)
  );

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ 8'hA5;
  endfunction

  assign fetchData = {memByte(fetchAddr + 16'd1), memByte(fetchAddr)};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chkPeek(input string req, input int n, input logic [15:0] base);
    check({req, " peekCount"}, 32'(peekCount), 32'(n));
    for (int k = 0; k < n; k++)
      check({req, " peek byte"}, 32'(peekData[8*k +: 8]), 32'(memByte(base + 16'(k))));
  endtask

  task automatic drive(input logic fl, input logic [15:0] fa, input logic pv,
                       input logic [1:0] ps, input logic gr);
    flushValid = fl; flushAddr = fa; popValid = pv; popSize = ps; fetchGrant = gr;
    #1;
  endtask

  task automatic tick;
    @(posedge clk); #1;
    flushValid = 1'b0; popValid = 1'b0; popSize = 2'd0; fetchGrant = 1'b0;
    #1;
  endtask

  task automatic doFlush(input logic [15:0] a);
    drive(1'b1, a, 1'b0, 2'd0, 1'b0);
    tick();
  endtask

  task automatic t_reset;
    check("R1 empty", 32'(peekCount), 0);
    check("R1 fetchReq", 32'(fetchReq), 1);
    check("R1 fetchAddr", 32'(fetchAddr), 0);
  endtask

  task automatic t_aligned_fill;
    doFlush(16'h0040);
    check("R2 addr after flush", 32'(fetchAddr), 32'h40);
    drive(1'b0, 0, 1'b0, 2'd0, 1'b1); tick();
    chkPeek("R3 first word", 2, 16'h0040);
    check("R2 addr advance", 32'(fetchAddr), 32'h42);
    drive(1'b0, 0, 1'b0, 2'd0, 1'b1); tick();
    chkPeek("R5 two words", 3, 16'h0040);
    check("R10 no req at four", 32'(fetchReq), 0);
    drive(1'b0, 0, 1'b0, 2'd0, 1'b1); tick();
    check("R2 grant ignored", 32'(fetchAddr), 32'h44);
  endtask

  task automatic t_pop_sizes;
    drive(1'b0, 0, 1'b1, 2'd1, 1'b0);
    check("R6 ready pop1", 32'(popReady), 1);
    tick();
    chkPeek("R6 pop1", 3, 16'h0041);
    check("R2 req at two free", 32'(fetchReq), 1);
    drive(1'b0, 0, 1'b1, 2'd3, 1'b0); tick();
    check("R6 pop3 empties", 32'(peekCount), 0);
  endtask

  task automatic t_refuse;
    drive(1'b0, 0, 1'b0, 2'd0, 1'b1); tick();
    chkPeek("R3 refill", 2, 16'h0044);
    drive(1'b0, 0, 1'b1, 2'd3, 1'b0);
    check("R7 popReady low", 32'(popReady), 0);
    tick();
    chkPeek("R7 unchanged", 2, 16'h0044);
    drive(1'b0, 0, 1'b0, 2'd2, 1'b0);
    check("R7 size2 ready", 32'(popReady), 1);
    tick();
  endtask

  task automatic t_odd_flush;
    doFlush(16'h0061);
    check("R4 aligned addr", 32'(fetchAddr), 32'h60);
    drive(1'b0, 0, 1'b0, 2'd0, 1'b1); tick();
    chkPeek("R4 high lane only", 1, 16'h0061);
    check("R4 next even", 32'(fetchAddr), 32'h62);
    drive(1'b0, 0, 1'b0, 2'd0, 1'b1); tick();
    chkPeek("R4 after odd", 3, 16'h0061);
  endtask

  task automatic t_flush_discard;
    drive(1'b1, 16'h0080, 1'b1, 2'd1, 1'b1);
    check("R8 popReady low", 32'(popReady), 0);
    check("R8 fetchReq low", 32'(fetchReq), 0);
    tick();
    check("R8 emptied", 32'(peekCount), 0);
    check("R8 new addr", 32'(fetchAddr), 32'h80);
  endtask

  task automatic t_concurrent;
    drive(1'b0, 0, 1'b0, 2'd0, 1'b1); tick();
    chkPeek("R3 word", 2, 16'h0080);
    drive(1'b0, 0, 1'b1, 2'd1, 1'b1); tick();
    chkPeek("R9 pop1+fill", 3, 16'h0081);
    drive(1'b0, 0, 1'b1, 2'd2, 1'b1); tick();
    chkPeek("R9 pop2+fill", 3, 16'h0083);
    check("R9 addr", 32'(fetchAddr), 32'h86);
  endtask

  task automatic t_full;
    doFlush(16'h00C1);
    drive(1'b0, 0, 1'b0, 2'd0, 1'b1); tick();
    drive(1'b0, 0, 1'b0, 2'd0, 1'b1); tick();
    check("R10 req at three", 32'(fetchReq), 1);
    drive(1'b0, 0, 1'b0, 2'd0, 1'b1); tick();
    check("R10 no req when full", 32'(fetchReq), 0);
    check("R10 addr", 32'(fetchAddr), 32'hC6);
    drive(1'b0, 0, 1'b1, 2'd2, 1'b0); tick();
    chkPeek("R10 five held", 3, 16'h00C3);
    drive(1'b0, 0, 1'b1, 2'd3, 1'b0); tick();
    check("R6 drained", 32'(peekCount), 0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    fails++;
    $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    flushValid = 1'b0; flushAddr = '0; popValid = 1'b0; popSize = 2'd0; fetchGrant = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    t_reset();
    t_aligned_fill();
    t_pop_sizes();
    t_refuse();
    t_odd_flush();
    t_flush_discard();
    t_concurrent();
    t_full();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule